// File: doc/BRIEF.md
# Sticky GPIO Input/Output Controller

This block manages a bank of general-purpose pins. Each pin is either handed to its alternate function or taken over as a GPIO. As a GPIO it can drive a value held in a level register, and that value can be set to toggle at a slow fixed rate. Pin inputs pass through a two-sample qualifier and are then held in sticky status bits until software clears them. Each held event raises one of two event outputs, chosen per pin: a system control interrupt (SCI) or a system management interrupt (SMI).

Sampling follows the power state. While the system is awake, input samples are taken on a fast bus-clock enable. While it sleeps, they are taken on a slow real-time-clock enable. Software reaches six registers through a simple synchronous port. Writes take effect at the clock edge and reads are combinational from the address. Pins that the build marks as absent have no storage behind them.

Top module: `sticky_gpio_ctrl`

## Requirements
- R1: After reset every pin selects its alternate function (`alt_sel` all ones, use-select reads 0) and every implemented pin is an input (direction reads the implemented mask). Level, blink, route and status all read 0, `pin_oe` is 0, and `sci` and `smi` are low.
- R2: The sample enable is `slow_tick` when `sleep` is 1 and `fast_tick` when `sleep` is 0. A status bit is set only at a sample in which the pin is high and was also high at the previous sample.
- R3: A status bit that is set stays set after its input falls, until software clears it.
- R4: Writing register 5 (status) clears every bit written as 1. If a qualified assertion arrives in the same cycle as the clear, the bit stays set.
- R5: `pin_oe` is 1 for a pin whose use-select bit is 1 and whose direction bit is 0. A direction bit of 1 means input. When blink is off, `pin_out` equals the bit in the level register.
- R6: With its blink bit set, a pin's output is its level XOR a phase that inverts once every 2^BLINK_LOG2 `slow_tick` pulses, counted from reset. Clearing the blink bit returns the output to the level value.
- R7: `sci` is the OR of the status bits that have route 0 and use-select 1. `smi` is the OR of the status bits that have route 1 and use-select 1.
- R8: Pins that are clear in IMPL_MASK read as 0 in every register, ignore writes, never set status, and keep `pin_out` and `pin_oe` at 0.
- R9: The register addresses are 0 use-select (1 selects GPIO), 1 direction, 2 level, 3 blink enable, 4 route (1 selects SMI) and 5 status. Addresses 6 and 7 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | 1 in sleep states, 0 in working states |
| fast_tick | input | 1 | Bus-clock sample enable |
| slow_tick | input | 1 | Real-time-clock sample and blink enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | NPINS | Write data |
| rdata | output | NPINS | Read data for `addr` |
| pin_in | input | NPINS | Pin input levels |
| pin_out | output | NPINS | Pin output values |
| pin_oe | output | NPINS | Pin output enables |
| alt_sel | output | NPINS | 1 where the pin uses its alternate function |
| sci | output | 1 | SCI event |
| smi | output | 1 | SMI event |

## Verification
The properties assume that every input is a known value from the release of reset onward. They also assume that `fast_tick` and `slow_tick` are sampled at the edge exactly like data, so that a tick is a one-cycle pulse. The stimulus changes every input on the falling clock edge and keeps the tick pulses one cycle wide. Before the blink checks start, it issues only a tracked number of `slow_tick` pulses, so the expected blink phase follows from that count alone.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_USE   = 3'd0,
        REG_DIR   = 3'd1,
        REG_LVL   = 3'd2,
        REG_BLINK = 3'd3,
        REG_ROUTE = 3'd4,
        REG_STAT  = 3'd5
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sample_qual.sv
module gpio_sample_qual #(
    parameter int          N    = 8,
    parameter logic [N-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample_en,
    input  logic [N-1:0] pin_in,
    input  logic [N-1:0] clr,
    output logic [N-1:0] status
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] stat;
    } qual_t;

    qual_t q_d, q_q;
    logic [N-1:0] hit;

    always_comb begin
        q_d = q_q;
        hit = pin_in & q_q.prev & IMPL & {N{sample_en}};
        if (sample_en) q_d.prev = pin_in;
        q_d.stat = (q_q.stat & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign status = q_q.stat;

    // R2
    qualified_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & ~$past(status) & ~$past(pin_in & q_q.prev & {N{sample_en}})) == '0));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(status & ~clr)) == $past(status & ~clr)));

    // R4
    set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_blink_timer.sv
module gpio_blink_timer #(
    parameter int BLINK_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick,
    output logic phase
);
    typedef struct packed {
        logic [BLINK_LOG2-1:0] cnt;
        logic                  ph;
    } blink_t;

    blink_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (slow_tick) begin
            b_d.cnt = b_q.cnt + 1'b1;
            if (&b_q.cnt) b_d.ph = ~b_q.ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign phase = b_q.ph;

    // R6
    phase_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_tick |=> $stable(phase));
endmodule

// File: rtl/sticky_gpio_ctrl.sv
module sticky_gpio_ctrl #(
    parameter int              NPINS      = 8,
    parameter logic [NPINS-1:0] IMPL_MASK = 8'hBF,
    parameter int              BLINK_LOG2 = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             fast_tick,
    input  logic             slow_tick,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] rdata,
    input  logic [NPINS-1:0] pin_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] alt_sel,
    output logic             sci,
    output logic             smi
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [NPINS-1:0] use_sel;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] level;
        logic [NPINS-1:0] blink;
        logic [NPINS-1:0] route;
    } regs_t;

    regs_t s_d, s_q;
    logic [NPINS-1:0] clr, status;
    logic sample_en, phase;

    assign sample_en = sleep ? slow_tick : fast_tick;

    always_comb begin
        s_d = s_q;
        clr = '0;
        if (wr_en) begin
            case (addr)
                REG_USE:   s_d.use_sel = wdata & IMPL_MASK;
                REG_DIR:   s_d.dir     = wdata & IMPL_MASK;
                REG_LVL:   s_d.level   = wdata & IMPL_MASK;
                REG_BLINK: s_d.blink   = wdata & IMPL_MASK;
                REG_ROUTE: s_d.route   = wdata & IMPL_MASK;
                REG_STAT:  clr         = wdata & IMPL_MASK;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.dir <= IMPL_MASK;
        end else begin
            s_q <= s_d;
        end
    end

    gpio_sample_qual #(.N(NPINS), .IMPL(IMPL_MASK)) u_qual (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
        .pin_in(pin_in), .clr(clr), .status(status)
    );

    gpio_blink_timer #(.BLINK_LOG2(BLINK_LOG2)) u_blink (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .phase(phase)
    );

    always_comb begin
        case (addr)
            REG_USE:   rdata = s_q.use_sel;
            REG_DIR:   rdata = s_q.dir;
            REG_LVL:   rdata = s_q.level;
            REG_BLINK: rdata = s_q.blink;
            REG_ROUTE: rdata = s_q.route;
            REG_STAT:  rdata = status;
            default:   rdata = '0;
        endcase
    end

    assign pin_out = (s_q.level ^ (s_q.blink & {NPINS{phase}})) & IMPL_MASK;
    assign pin_oe  = s_q.use_sel & ~s_q.dir & IMPL_MASK;
    assign alt_sel = ~s_q.use_sel;
    assign sci     = |(status & s_q.use_sel & ~s_q.route);
    assign smi     = |(status & s_q.use_sel & s_q.route);

    // R5
    level_drives_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == REG_LVL && s_q.blink == '0)
        |=> ((pin_out & ~s_q.blink) == ($past(wdata) & IMPL_MASK & ~s_q.blink)));

    // R7
    event_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & s_q.use_sel) == '0 |-> !(sci || smi));
endmodule

// File: tb/tb_sticky_gpio_ctrl.sv
module tb_sticky_gpio_ctrl;
    localparam int N = 8;
    localparam logic [N-1:0] IMPL = 8'hBF;

    logic clk = 0, rst_n = 0, sleep = 0, fast_tick = 0, slow_tick = 0, wr_en = 0;
    logic [2:0] addr = '0;
    logic [N-1:0] wdata = '0, pin_in = '0;
    logic [N-1:0] rdata, pin_out, pin_oe, alt_sel;
    logic sci, smi;
    int checks = 0, errors = 0, slow_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sticky_gpio_ctrl #(.NPINS(N), .IMPL_MASK(IMPL), .BLINK_LOG2(2)) dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .fast_tick(fast_tick),
        .slow_tick(slow_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .alt_sel(alt_sel), .sci(sci), .smi(smi)
    );

    // {sleep, fast, slow, pin_in, expected status}
    localparam logic [18:0] VEC [12] = '{
        {3'b010, 8'h01, 8'h00}, {3'b010, 8'h01, 8'h01}, {3'b000, 8'h02, 8'h01},
        {3'b010, 8'h02, 8'h01}, {3'b010, 8'h00, 8'h01}, {3'b110, 8'h04, 8'h01},
        {3'b101, 8'h04, 8'h01}, {3'b101, 8'h44, 8'h05}, {3'b101, 8'h44, 8'h05},
        {3'b001, 8'h80, 8'h05}, {3'b010, 8'h80, 8'h05}, {3'b010, 8'h80, 8'h85}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        if (slow_tick) slow_cnt++;
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1; addr = a; wdata = d;
        cyc();
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [N-1:0] exp);
        addr = a; #1;
        chk(req, rdata, exp);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        rd(0, "R1 use_sel", 8'h00);
        rd(1, "R1 dir", IMPL);
        rd(2, "R1 level", 8'h00);
        rd(5, "R1 status", 8'h00);
        chk("R1 alt_sel", alt_sel, 8'hFF);
        chk("R1 oe/sci/smi", {pin_oe, sci, smi}, '0);

        // R2 R3 R8 qualification table
        for (int i = 0; i < 12; i++) begin
            {sleep, fast_tick, slow_tick, pin_in} = VEC[i][18:8];
            cyc();
            rd(5, "R2 R3 R8 status vector", VEC[i][7:0]);
        end
        {sleep, fast_tick, slow_tick, pin_in} = '0;

        // R4 write-one-to-clear and set override
        wr(5, 8'h01);
        rd(5, "R4 w1c", 8'h84);
        pin_in = 8'h01; fast_tick = 1;
        cyc();
        wr(5, 8'h01);
        rd(5, "R4 set beats clear", 8'h85);
        pin_in = 0; fast_tick = 0;
        wr(5, 8'h81);
        rd(5, "R4 w1c two bits", 8'h04);

        // R8 unimplemented pin ignores writes; R7 routing
        wr(0, 8'hFF);
        rd(0, "R8 use_sel masked", 8'hBF);
        chk("R1 R8 alt_sel", alt_sel, 8'h40);
        chk("R7 sci route0", {sci, smi}, 2'b10);
        wr(4, 8'h04);
        chk("R7 smi route1", {sci, smi}, 2'b01);
        wr(0, 8'h00);
        chk("R7 masked by use_sel", {sci, smi}, 2'b00);
        wr(0, 8'hFF);

        // R5 output drive
        wr(1, 8'h00);
        chk("R5 R8 oe", pin_oe, 8'hBF);
        wr(2, 8'hE5);
        rd(2, "R8 level masked", 8'hA5);
        chk("R5 pin_out", pin_out, 8'hA5);
        wr(1, 8'h01);
        chk("R5 dir input tristates", pin_oe, 8'hBE);

        // R9 unused addresses
        wr(6, 8'hFF);
        rd(6, "R9 addr6", 8'h00);
        rd(7, "R9 addr7", 8'h00);
        rd(2, "R9 level untouched", 8'hA5);

        // R6 blink
        wr(3, 8'h01);
        for (int k = 0; k < 7; k++) begin
            chk("R6 blink phase", pin_out[0], 1'b1 ^ slow_cnt[2]);
            slow_tick = 1;
            cyc();
            slow_tick = 0;
        end
        wr(3, 8'h00);
        chk("R6 blink off returns level", pin_out, 8'hA5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule